// File: doc/BRIEF.md
# Rational-Ratio Second-Order CIC Resampler

This block changes the sample rate of a complex (I/Q) stream by the rational factor L/M with a fixed-coefficient, multiplier-free second-order cascaded integrator-comb filter. It sits right after a digital down-converter's frequency translator. Each lane, I and Q, runs the same filter on its own data.

Each accepted input sample is treated as if it were followed by L−1 zeros. The two integrators advance once for every such upsampled step, at one step per clock. A modulo-M count over the steps picks every M-th integrator value and passes it into two comb sections, whose differential delay is one output sample. The comb result is scaled by a programmable arithmetic right shift, rounded and saturated, and then leaves the block with a one-cycle valid pulse.

The interpolation factor, the decimation factor and the shift are captured from their configuration inputs only while the synchronous reset is held. The same reset clears all filter state. Input samples must be spaced at least L clocks apart.

Top module: `rcic2_resampler`

## Requirements
- R1: The values of `l_cfg`, `m_cfg` and `shift_cfg` are captured on every clock edge at which `rst` is high, and changes to them while `rst` is low have no effect. A captured value of 0 for L or M is used as 1.
- R2: The reset is synchronous. One clock with `rst` high clears both integrators, both comb delays and the output registers, so that `out_valid`, `out_i` and `out_q` read 0 until the first new output.
- R3: When `in_valid` is high and no sample is in progress, the sample is accepted and L−1 zero-valued steps follow on the next L−1 clocks. `in_valid` is ignored on those L−1 clocks.
- R4: The block produces exactly one output every M upsampled steps. The first output comes from step M−1, counting from 0 after reset, so N accepted inputs yield floor(N·L/M) outputs.
- R5: Output k, before scaling, equals the sum over j = 0..2M−2 of h(j)·u((k+1)·M−1−j). Here u is the zero-stuffed input sequence (u(p) = x(p/L) when p mod L = 0, else 0, and 0 for p < 0) and h(j) = j+1 for j < M, else 2M−1−j. The I and Q lanes are computed independently and in the same way.
- R6: Scaling by a shift S > 0 computes (v + 2^(S−1)) arithmetically shifted right by S, which rounds half-way values upward. S = 0 passes v unchanged. S may range from 0 to DW+2·MW.
- R7: A scaled value outside the signed OW-bit range is clamped to −2^(OW−1) or 2^(OW−1)−1.
- R8: `out_valid` is high for exactly one clock per output. It rises in the clock that follows the edge at which the deciding step is taken. With L = M = 1, an input sampled at one edge appears on the outputs after the next edge.
- R9: The integrators are DW+2·MW bits wide and wrap modulo their width. Outputs stay exact after the integrators have wrapped many times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also captures configuration |
| l_cfg | input | LW | Interpolation factor L |
| m_cfg | input | MW | Decimation factor M |
| shift_cfg | input | SHW | Output right-shift amount |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | DW | In-phase input sample, two's complement |
| in_q | input | DW | Quadrature input sample, two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | OW | In-phase output sample, two's complement |
| out_q | output | OW | Quadrature output sample, two's complement |

## Verification
The filter is driven with a constant level, an alternating-sign sequence, a short ramp and a single impulse. The constant shows the steady-state gain of M²/L. The alternating sequence shows the rejection of high frequencies, the ramp exposes misaligned comb delays, and the impulse reads out the triangular kernel tap by tap. The ratios cover pure decimation, pure interpolation, L = M and mixed L/M. The Q lane always carries the negated I data, so the rounding direction and negative clamping are seen next to their positive counterparts. A long run at the largest L and M wraps the integrators. Directed cases then cover reset clearing, configuration changes outside reset, zero-valued configuration, inputs that arrive while zeros are being stuffed, the position of the first output and the latency.

// File: rtl/rcic_pkg.sv
package rcic_pkg;

    // number of parallel data lanes (in-phase and quadrature)
    localparam int unsigned LANES = 2;

    // per-cycle strobes handed from the sequencer to the lanes
    typedef struct packed {
        logic step;  // integrators advance one upsampled step
        logic load;  // this step carries a real input sample
        logic dec;   // this step's integrator value feeds the combs
    } rcic_strobe_t;

endpackage

// File: rtl/rcic_ctrl.sv
module rcic_ctrl
    import rcic_pkg::*;
#(
    parameter int unsigned LW  = 4,
    parameter int unsigned MW  = 4,
    parameter int unsigned SHW = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [LW-1:0]      l_cfg,
    input  logic [MW-1:0]      m_cfg,
    input  logic [SHW-1:0]     shift_cfg,
    output rcic_strobe_t       strb,
    output logic [LW-1:0]      l_cur,
    output logic [MW-1:0]      m_cur,
    output logic [SHW-1:0]     sh_cur,
    output logic               busy
);

    typedef struct packed {
        logic [LW-1:0]  l;     // captured interpolation factor
        logic [MW-1:0]  m;     // captured decimation factor
        logic [SHW-1:0] sh;    // captured shift
        logic [LW-1:0]  ph;    // zero-stuffing phase, 0 = idle
        logic [MW-1:0]  dc;    // steps since the last decimated step
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        strb   = '0;
        if (rst) begin
            // R1: configuration is taken only here, zero maps to one
            ctrl_d.l  = (l_cfg == '0) ? LW'(1) : l_cfg;
            ctrl_d.m  = (m_cfg == '0) ? MW'(1) : m_cfg;
            ctrl_d.sh = shift_cfg;
            ctrl_d.ph = '0;
            ctrl_d.dc = '0;
        end else begin
            // R3: a sample is only taken when no zero-stuffing is pending
            strb.load = in_valid && (ctrl_q.ph == '0);
            strb.step = strb.load || (ctrl_q.ph != '0);
            // R4: every M-th step is passed to the combs
            strb.dec  = strb.step && (ctrl_q.dc == ctrl_q.m - MW'(1));
            if (strb.step) begin
                ctrl_d.ph = (ctrl_q.ph == ctrl_q.l - LW'(1)) ? '0 : ctrl_q.ph + LW'(1);
                ctrl_d.dc = strb.dec ? '0 : ctrl_q.dc + MW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        ctrl_q <= ctrl_d;
    end

    assign l_cur  = ctrl_q.l;
    assign m_cur  = ctrl_q.m;
    assign sh_cur = ctrl_q.sh;
    assign busy   = (ctrl_q.ph != '0);

endmodule

// File: rtl/rcic_lane.sv
module rcic_lane
    import rcic_pkg::*;
#(
    parameter int unsigned DW  = 12,
    parameter int unsigned OW  = 12,
    parameter int unsigned AW  = 20,
    parameter int unsigned SHW = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  rcic_strobe_t       strb,
    input  logic [DW-1:0]      x,
    input  logic [SHW-1:0]     sh,
    output logic [OW-1:0]      y
);

    localparam longint OMAX = (64'sd1 <<< (OW - 1)) - 64'sd1;
    localparam longint OMIN = -(64'sd1 <<< (OW - 1));

    typedef struct packed {
        logic [AW-1:0] i1;   // first integrator
        logic [AW-1:0] i2;   // second integrator
        logic [AW-1:0] z1;   // first comb delay
        logic [AW-1:0] z2;   // second comb delay
        logic [OW-1:0] y;    // scaled output
    } lane_t;

    lane_t lane_d, lane_q;

    logic [AW-1:0] xin;
    logic [AW-1:0] i1_n;
    logic [AW-1:0] i2_n;
    logic [AW-1:0] c1;
    logic [AW-1:0] c2;

    // R6/R7: round-half-up arithmetic shift, then clamp to OW bits
    function automatic logic [OW-1:0] scale_sat(input logic [AW-1:0] v,
                                                 input logic [SHW-1:0] s);
        longint lv;
        longint r;
        lv = longint'($signed(v));
        if (s == '0) begin
            r = lv;
        end else begin
            r = (lv + (64'sd1 <<< (s - SHW'(1)))) >>> s;
        end
        if (r > OMAX) begin
            r = OMAX;
        end else if (r < OMIN) begin
            r = OMIN;
        end
        return r[OW-1:0];
    endfunction

    always_comb begin
        lane_d = lane_q;
        // zero-stuffed input: only a load step carries data
        xin  = strb.load ? {{(AW - DW){x[DW-1]}}, x} : '0;
        // R9: modulo-2^AW integrators
        i1_n = lane_q.i1 + xin;
        i2_n = lane_q.i2 + i1_n;
        // R5: two combs, delay of one output sample each
        c1   = i2_n - lane_q.z1;
        c2   = c1 - lane_q.z2;
        if (rst) begin
            lane_d = '0;
        end else if (strb.step) begin
            lane_d.i1 = i1_n;
            lane_d.i2 = i2_n;
            if (strb.dec) begin
                lane_d.z1 = i2_n;
                lane_d.z2 = c1;
                lane_d.y  = scale_sat(c2, sh);
            end
        end
    end

    always_ff @(posedge clk) begin
        lane_q <= lane_d;
    end

    assign y = lane_q.y;

endmodule

// File: rtl/rcic2_resampler.sv
module rcic2_resampler
    import rcic_pkg::*;
#(
    parameter int unsigned DW  = 12,
    parameter int unsigned OW  = 12,
    parameter int unsigned LW  = 4,
    parameter int unsigned MW  = 4,
    parameter int unsigned SHW = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LW-1:0]      l_cfg,
    input  logic [MW-1:0]      m_cfg,
    input  logic [SHW-1:0]     shift_cfg,
    input  logic               in_valid,
    input  logic [DW-1:0]      in_i,
    input  logic [DW-1:0]      in_q,
    output logic               out_valid,
    output logic [OW-1:0]      out_i,
    output logic [OW-1:0]      out_q
);

    // integrator growth: M squared needs 2*MW extra bits
    localparam int unsigned AW = DW + 2 * MW;

    typedef struct packed {
        logic vld;
    } top_t;

    rcic_strobe_t    strb;
    logic [LW-1:0]   l_cur;
    logic [MW-1:0]   m_cur;
    logic [SHW-1:0]  sh_cur;
    logic            busy;
    logic [DW-1:0]   lane_x [LANES];
    logic [OW-1:0]   lane_y [LANES];
    top_t            top_d, top_q;

    rcic_ctrl #(
        .LW  (LW),
        .MW  (MW),
        .SHW (SHW)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .l_cfg     (l_cfg),
        .m_cfg     (m_cfg),
        .shift_cfg (shift_cfg),
        .strb      (strb),
        .l_cur     (l_cur),
        .m_cur     (m_cur),
        .sh_cur    (sh_cur),
        .busy      (busy)
    );

    assign lane_x[0] = in_i;
    assign lane_x[1] = in_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rcic_lane #(
            .DW  (DW),
            .OW  (OW),
            .AW  (AW),
            .SHW (SHW)
        ) u_lane (
            .clk  (clk),
            .rst  (rst),
            .strb (strb),
            .x    (lane_x[g]),
            .sh   (sh_cur),
            .y    (lane_y[g])
        );
    end

    always_comb begin
        top_d     = top_q;
        top_d.vld = rst ? 1'b0 : strb.dec;
    end

    always_ff @(posedge clk) begin
        top_q <= top_d;
    end

    assign out_valid = top_q.vld;
    assign out_i     = lane_y[0];
    assign out_q     = lane_y[1];

endmodule

// File: rtl/rcic2_resampler_chk.sv
module rcic2_resampler_chk
    import rcic_pkg::*;
#(
    parameter int unsigned OW = 12,
    parameter int unsigned LW = 4,
    parameter int unsigned MW = 4
) (
    input logic             clk,
    input logic             rst,
    input rcic_strobe_t     strb,
    input logic             busy,
    input logic [LW-1:0]    l_cur,
    input logic [MW-1:0]    m_cur,
    input logic             out_valid,
    input logic [OW-1:0]    out_i,
    input logic [OW-1:0]    out_q
);

    // steps seen since the last decimated step, counted independently
    logic [MW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= '0;
        end else if (strb.step) begin
            gap_q <= strb.dec ? '0 : gap_q + MW'(1);
        end
    end

    // R1: captured configuration holds outside reset
    p_cfg_hold_r1: assert property (@(posedge clk) disable iff (rst)
        $stable(l_cur) && $stable(m_cur));

    // R2: first cycle after reset shows cleared outputs
    p_reset_clear_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && out_i == '0 && out_q == '0));

    // R3: no sample taken while zeros are being stuffed
    p_busy_no_load_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> !strb.load);

    // R3: a sample with L above one is followed by a zero step
    p_stuff_follows_r3: assert property (@(posedge clk) disable iff (rst)
        (strb.load && l_cur != LW'(1)) |=> (strb.step && busy));

    // R4: decimation happens exactly on the M-th step
    p_dec_spacing_r4: assert property (@(posedge clk) disable iff (rst)
        strb.dec |-> (strb.step && gap_q == m_cur - MW'(1)));

    p_dec_due_r4: assert property (@(posedge clk) disable iff (rst)
        (strb.step && gap_q == m_cur - MW'(1)) |-> strb.dec);

    // R8: one valid pulse per decimated step, one cycle later
    p_valid_follows_r8: assert property (@(posedge clk) disable iff (rst)
        strb.dec |=> out_valid);

    p_valid_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !strb.dec |=> !out_valid);

endmodule

bind rcic2_resampler rcic2_resampler_chk #(
    .OW (OW),
    .LW (LW),
    .MW (MW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .busy      (busy),
    .l_cur     (l_cur),
    .m_cur     (m_cur),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
);

// File: tb/rcic2_resampler_test.sv
module rcic2_resampler_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW  = 12;
    localparam int OW  = 12;
    localparam int LW  = 4;
    localparam int MW  = 4;
    localparam int SHW = 5;
    localparam int NIN = 12;
    localparam int CAP = 256;

    // stimulus pattern codes: 0 constant, 1 alternating, 2 ramp, 3 impulse
    typedef struct packed {
        int l;
        int m;
        int sh;
        int pat;
        int amp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1,  1, 0, 0,  100},   // pass-through
        '{1,  4, 4, 0,  300},   // pure decimation, DC gain
        '{3,  2, 2, 2,   50},   // mixed ratio, ramp
        '{2,  5, 3, 1, 1000},   // alternating sign
        '{4,  3, 1, 3, 2000},   // impulse response, interpolating
        '{1,  8, 0, 0, 2000},   // clamping (R7)
        '{5,  5, 2, 2, -200},   // L equal to M
        '{15, 15, 7, 0, 1500},  // integrator wrap (R9)
        '{1,  2, 3, 0,    5}    // half-way rounding (R6)
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [LW-1:0]    l_cfg = '0;
    logic [MW-1:0]    m_cfg = '0;
    logic [SHW-1:0]   shift_cfg = '0;
    logic             in_valid = 1'b0;
    logic [DW-1:0]    in_i = '0;
    logic [DW-1:0]    in_q = '0;
    logic             out_valid;
    logic [OW-1:0]    out_i;
    logic [OW-1:0]    out_q;

    int n_chk  = 0;
    int n_fail = 0;
    int cap_n  = 0;
    longint cap_i [CAP];
    longint cap_q [CAP];

    rcic2_resampler #(
        .DW (DW), .OW (OW), .LW (LW), .MW (MW), .SHW (SHW)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .l_cfg     (l_cfg),
        .m_cfg     (m_cfg),
        .shift_cfg (shift_cfg),
        .in_valid  (in_valid),
        .in_i      (in_i),
        .in_q      (in_q),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // collect outputs away from the active edge
    always @(negedge clk) begin
        if (out_valid && cap_n < CAP) begin
            cap_i[cap_n] = longint'($signed(out_i));
            cap_q[cap_n] = longint'($signed(out_q));
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int samp(input int pat, input int amp, input int i);
        case (pat)
            0:       return amp;
            1:       return (i % 2 == 1) ? -amp : amp;
            2:       return amp * ((i % 5) - 2);
            default: return (i == 0) ? amp : 0;
        endcase
    endfunction

    // R6/R7 scaling as stated in the requirements
    function automatic longint scale(input longint v, input int sh);
        longint r;
        longint hi;
        longint lo;
        hi = (64'sd1 <<< (OW - 1)) - 1;
        lo = -(64'sd1 <<< (OW - 1));
        r  = (sh == 0) ? v : ((v + (64'sd1 <<< (sh - 1))) >>> sh);
        if (r > hi) r = hi;
        if (r < lo) r = lo;
        return r;
    endfunction

    // R5: direct triangular-kernel convolution of the zero-stuffed input
    function automatic longint model(input int l, input int m, input int sh,
                                     input int pat, input int amp, input int sgn,
                                     input int k);
        longint acc;
        int last;
        acc  = 0;
        last = (k + 1) * m - 1;
        for (int j = 0; j <= 2 * m - 2; j++) begin
            int p;
            int h;
            p = last - j;
            h = (j < m) ? j + 1 : 2 * m - 1 - j;
            if (p >= 0 && (p % l) == 0 && (p / l) < NIN) begin
                acc = acc + longint'(h) * longint'(sgn * samp(pat, amp, p / l));
            end
        end
        return scale(acc, sh);
    endfunction

    task automatic do_reset(input int l, input int m, input int sh);
        @(negedge clk);
        rst       = 1'b1;
        in_valid  = 1'b0;
        l_cfg     = LW'(l);
        m_cfg     = MW'(m);
        shift_cfg = SHW'(sh);
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic drive(input int xi);
        in_valid = 1'b1;
        in_i     = DW'(xi);
        in_q     = DW'(-xi);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail = n_fail + 1;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int base;

        // vector table: R4 count, R5 values, R6 rounding, R7 clamp, R9 wrap;
        // each reset here also clears the previous vector's state (R2)
        for (int v = 0; v < NV; v++) begin
            vec_t t;
            int nout;
            t = VECS[v];
            do_reset(t.l, t.m, t.sh);
            base = cap_n;
            for (int i = 0; i < NIN; i++) begin
                @(negedge clk);
                drive(samp(t.pat, t.amp, i));
                repeat (t.l - 1) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                end
            end
            @(negedge clk);
            in_valid = 1'b0;
            repeat (t.l + 3) @(negedge clk);
            nout = (NIN * t.l) / t.m;
            chk("R4 output count", longint'(cap_n - base), longint'(nout));
            for (int k = 0; k < nout; k++) begin
                chk("R5 I value", cap_i[base + k], model(t.l, t.m, t.sh, t.pat, t.amp, 1, k));
                chk("R5 Q value", cap_q[base + k], model(t.l, t.m, t.sh, t.pat, t.amp, -1, k));
            end
        end

        // R2: reset after activity leaves outputs cleared
        do_reset(1, 1, 0);
        chk("R2 out_valid after reset", longint'(out_valid), 0);
        chk("R2 out_i after reset", longint'($signed(out_i)), 0);
        chk("R2 out_q after reset", longint'($signed(out_q)), 0);

        // R1: configuration moved outside reset has no effect
        base = cap_n;
        @(negedge clk);
        l_cfg = 4'd3; m_cfg = 4'd2; shift_cfg = 5'd4;
        drive(5);
        @(negedge clk); drive(-7);
        @(negedge clk); drive(300);
        @(negedge clk); drive(-2000);
        @(negedge clk); in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 count with moved config", longint'(cap_n - base), 4);
        chk("R1 sample 0", cap_i[base + 0], 5);
        chk("R1 sample 1", cap_i[base + 1], -7);
        chk("R1 sample 2", cap_i[base + 2], 300);
        chk("R1 sample 3", cap_q[base + 3], 2000);

        // R1: zero configuration behaves as one
        do_reset(0, 0, 0);
        base = cap_n;
        @(negedge clk); drive(11);
        @(negedge clk); drive(-22);
        @(negedge clk); in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 zero cfg count", longint'(cap_n - base), 2);
        chk("R1 zero cfg sample 0", cap_i[base + 0], 11);
        chk("R1 zero cfg sample 1", cap_q[base + 1], 22);

        // R3: inputs during zero-stuffing are ignored (L=3, M=1)
        do_reset(3, 1, 0);
        base = cap_n;
        @(negedge clk); drive(10);
        @(negedge clk); drive(20);
        @(negedge clk); drive(30);
        @(negedge clk); drive(40);
        @(negedge clk); in_valid = 1'b0;
        repeat (5) @(negedge clk);
        chk("R3 output count", longint'(cap_n - base), 6);
        chk("R3 out 0", cap_i[base + 0], 10);
        chk("R3 out 1", cap_i[base + 1], 0);
        chk("R3 out 2", cap_i[base + 2], 0);
        chk("R3 out 3", cap_i[base + 3], 40);
        chk("R3 out 4", cap_i[base + 4], 0);
        chk("R3 out 5 Q", cap_q[base + 5], 0);

        // R4: first output after step M-1 (M=3, one input per clock)
        do_reset(1, 3, 0);
        @(negedge clk); drive(1);
        for (int c = 1; c <= 6; c++) begin
            @(negedge clk);
            chk("R4 valid position", longint'(out_valid), (c % 3 == 0) ? 1 : 0);
            drive(1);
        end
        @(negedge clk); in_valid = 1'b0;

        // R8: one-cycle latency and single-cycle pulse
        do_reset(1, 1, 0);
        @(negedge clk); drive(77);
        @(negedge clk); in_valid = 1'b0;
        chk("R8 valid one edge later", longint'(out_valid), 1);
        chk("R8 data one edge later", longint'($signed(out_i)), 77);
        @(negedge clk);
        chk("R8 valid drops", longint'(out_valid), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule